// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Edge Capture

This block is a general-purpose I/O port of up to 32 pins, reached through a small word-addressed register bus. Software sets which pins drive, what value they drive and which pins may raise an interrupt. Software can also read the live state of every pin. Every pin input passes through a two-flop synchroniser before the port uses it. Transitions seen on the synchronised inputs are recorded in per-pin sticky capture bits. Software clears a capture bit by writing a one to its position.

The block has one interrupt output, and the trigger kind is fixed when the block is elaborated: rising edge, falling edge, both edges or level-high. In the three edge kinds, the interrupt is raised while any captured bit is also enabled in the mask. In level-high kind, the interrupt follows the enabled synchronised pin levels directly, and the capture register stays at zero. Pad tristate cells sit outside the block. They are driven from the output-value and output-enable buses.

Top module: `gpio_mmio_port`

## Requirements
- R1: After a synchronous active-low reset, the port is cleared. The output latch, direction, mask and capture registers all read zero, `pin_oe` and `pin_out` are zero, and `irq` and `rd_valid` are low.
- R2: Register selection uses address bits [3:2]. Value 0 (byte offset 0x0) is the output-data/pin register, 1 (0x4) is direction, 2 (0x8) is the interrupt mask and 3 (0xC) is edge capture. A read strobe in one cycle gives `rd_valid` high with `rd_data` in the next cycle, and `rd_valid` is low in every other cycle.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input. `pin_oe` equals the direction register and `pin_out` equals the output latch, each updated by the clock edge that takes the write.
- R4: Reading offset 0x0 returns the output latch for output pins and the synchronised pin level for input pins. A pin change becomes visible to a read issued two cycles later. Writing offset 0x0 changes only the output latch.
- R5: Register bits at and above `PIN_COUNT` read as zero, and writes to those bits are ignored.
- R6: In edge kinds, a capture bit is set by the selected transition of its synchronised pin. That is a 0-to-1 change for rising, 1-to-0 for falling and either change for both. The transition is found by comparing the synchronised value with its value one cycle earlier.
- R7: A capture bit stays set until a write of 1 to its position at offset 0xC. Writing 0 to a position leaves it unchanged.
- R8: When a new capture event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: In edge kinds, `irq` is high exactly while the AND of the capture and mask registers is non-zero.
- R10: In level-high kind, `irq` is high exactly while the AND of the synchronised pins and the mask is non-zero. The capture register reads zero in this kind and has no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; data returns one cycle later |
| addr | input | 4 | Byte address; bits [3:2] pick the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid |
| pin_in | input | PIN_COUNT | Raw, possibly asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output latch value toward the pads |
| pin_oe | output | PIN_COUNT | Per-pin output enable toward the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the bus strobes and address are synchronous to `clk` and stable around the edge that samples them. They also assume that `pin_in` may change at any time, because it is seen only through the synchroniser. The bench drives the bus and pins only on falling clock edges, so every rising edge samples settled values. The bench also fires read and write strobes in the same cycle, and it times a clearing write to land on the cycle in which a capture event arrives. The four trigger kinds are built side by side and share one bus and one set of pins. This lets the bench compare one stimulus stream against a behavioural model for every kind.

// File: rtl/gpio_pkg.sv
// Package: types shared by the GPIO port modules.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package gpio_pkg;

    // Interrupt trigger kind, fixed at elaboration.
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    // Register selected by address bits [3:2].
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_CAP  = 2'd3
    } reg_sel_e;

    localparam int BUS_W = 32;

endpackage

// File: rtl/gpio_sync2.sv
// Module: two-flop synchroniser, one chain per pin.
// Assumes the pin inputs are asynchronous to clk; reset drives the chains to 0.
module gpio_sync2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_chain
            logic meta_q;
            logic stable_q;

            // Two-stage capture of one pin into the clk domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q   <= 1'b0;
                    stable_q <= 1'b0;
                end else begin
                    meta_q   <= async_i[b];
                    stable_q <= meta_q;
                end
            end

            assign sync_o[b] = stable_q;
        end
    endgenerate

endmodule

// File: rtl/gpio_edge_cap.sv
// Module: edge detector and sticky per-pin capture register.
// Assumes pins_i is already synchronised. clr_i is a one-cycle mask of bits to
// clear (write-one-to-clear). A new event wins over a clear on the same bit.
// In level kind the register is held at zero.
module gpio_edge_cap
    import gpio_pkg::*;
#(
    parameter int    WIDTH   = 32,
    parameter trig_e TRIGGER = TRIG_BOTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] cap_o
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] evt;
    logic [WIDTH-1:0] cap_q;

    // One-cycle-old copy of the synchronised pins for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pins_i;
    end

    generate
        if (TRIGGER == TRIG_RISE) begin : g_rise
            assign evt = pins_i & ~prev_q;
        end else if (TRIGGER == TRIG_FALL) begin : g_fall
            assign evt = ~pins_i & prev_q;
        end else if (TRIGGER == TRIG_BOTH) begin : g_both
            assign evt = pins_i ^ prev_q;
        end else begin : g_level
            assign evt = '0;
        end
    endgenerate

    // Sticky capture: clear by written ones, set by events, events win.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr_i) | evt;
    end

    assign cap_o = cap_q;

    AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap_q & $past(cap_q & ~clr_i)) == $past(cap_q & ~clr_i))); // R7

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap_q & $past(evt)) == $past(evt))); // R8

endmodule

// File: rtl/gpio_regfile.sv
// Module: output latch, direction and mask registers, plus the bus read path.
// Assumes single-cycle write strobes and a word address in addr[3:2]. Reads
// return one cycle after rd_en, taken from state before that edge's update.
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [3:0]       addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [WIDTH-1:0] pins_i,
    input  logic [WIDTH-1:0] cap_i,
    output logic [WIDTH-1:0] out_o,
    output logic [WIDTH-1:0] dir_o,
    output logic [WIDTH-1:0] mask_o,
    output logic [WIDTH-1:0] clr_o,
    output logic [BUS_W-1:0] rd_data,
    output logic             rd_valid
);

    reg_sel_e         sel;
    logic [WIDTH-1:0] wval;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] rd_mux;
    logic [BUS_W-1:0] rd_q;
    logic             rv_q;

    // Zero-extend a pin-wide word onto the bus.
    function automatic logic [BUS_W-1:0] widen(input logic [WIDTH-1:0] v);
        logic [BUS_W-1:0] w;
        w = '0;
        w[WIDTH-1:0] = v;
        return w;
    endfunction

    assign sel  = reg_sel_e'(addr[3:2]);
    assign wval = wr_data[WIDTH-1:0];

    // Write side: update the register picked by the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DATA: out_q  <= wval;
                SEL_DIR:  dir_q  <= wval;
                SEL_MASK: mask_q <= wval;
                default:  ;
            endcase
        end
    end

    // Capture clear pulse: ones written to the capture offset.
    always_comb begin
        clr_o = '0;
        if (wr_en && sel == SEL_CAP) clr_o = wval;
    end

    // Read multiplexer: pin view merges latch and synchronised inputs.
    always_comb begin
        case (sel)
            SEL_DATA: rd_mux = (dir_q & out_q) | (~dir_q & pins_i);
            SEL_DIR:  rd_mux = dir_q;
            SEL_MASK: rd_mux = mask_q;
            default:  rd_mux = cap_i;
        endcase
    end

    // Registered read return with its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            rv_q <= 1'b0;
        end else begin
            rv_q <= rd_en;
            if (rd_en) rd_q <= widen(rd_mux);
        end
    end

    assign out_o    = out_q;
    assign dir_o    = dir_q;
    assign mask_o   = mask_q;
    assign rd_data  = rd_q;
    assign rd_valid = rv_q;

    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R2

    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R2

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data >> WIDTH) == '0)); // R5

endmodule

// File: rtl/gpio_mmio_port.sv
// Module: top of the memory-mapped GPIO port. Ties the synchroniser, the
// capture logic and the register file together and forms the interrupt.
// Assumes 1 <= PIN_COUNT <= 32 and a trigger kind fixed at elaboration.
module gpio_mmio_port
    import gpio_pkg::*;
#(
    parameter int    PIN_COUNT = 32,
    parameter trig_e TRIGGER   = TRIG_BOTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [3:0]           addr,
    input  logic [31:0]          wr_data,
    output logic [31:0]          rd_data,
    output logic                 rd_valid,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);

    logic [PIN_COUNT-1:0] pins_s;
    logic [PIN_COUNT-1:0] cap;
    logic [PIN_COUNT-1:0] clr;
    logic [PIN_COUNT-1:0] mask;
    logic [PIN_COUNT-1:0] irq_src;

    gpio_sync2 #(.WIDTH(PIN_COUNT)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pins_s)
    );

    gpio_edge_cap #(.WIDTH(PIN_COUNT), .TRIGGER(TRIGGER)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_s),
        .clr_i  (clr),
        .cap_o  (cap)
    );

    gpio_regfile #(.WIDTH(PIN_COUNT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .pins_i   (pins_s),
        .cap_i    (cap),
        .out_o    (pin_out),
        .dir_o    (pin_oe),
        .mask_o   (mask),
        .clr_o    (clr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Interrupt source: levels in level kind, captured edges otherwise.
    generate
        if (TRIGGER == TRIG_LEVEL) begin : g_irq_level
            assign irq_src = pins_s & mask;
        end else begin : g_irq_edge
            assign irq_src = cap & mask;
        end
    endgenerate

    assign irq = |irq_src;

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '0)); // R9

    AST_OE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pin_oe == '0)); // R1

endmodule

// File: tb/gpio_mmio_port_test.sv
`timescale 1ns/1ps
module gpio_mmio_port_test;
    import gpio_pkg::*;

    localparam int N = 12;
    localparam logic [N-1:0] ALL = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [N-1:0] pin_in = '0;

    // Index 0 both edges, 1 rising, 2 falling, 3 level-high.
    logic [31:0]  rd_w  [4];
    logic         rv_w  [4];
    logic [N-1:0] po_w  [4];
    logic [N-1:0] oe_w  [4];
    logic         irq_w [4];

    int n_chk = 0;
    int n_fail = 0;
    string phase = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_mmio_port #(.PIN_COUNT(N), .TRIGGER(TRIG_BOTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_w[0]), .rd_valid(rv_w[0]), .pin_in(pin_in),
        .pin_out(po_w[0]), .pin_oe(oe_w[0]), .irq(irq_w[0]));
    gpio_mmio_port #(.PIN_COUNT(N), .TRIGGER(TRIG_RISE)) uut_rise (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_w[1]), .rd_valid(rv_w[1]), .pin_in(pin_in),
        .pin_out(po_w[1]), .pin_oe(oe_w[1]), .irq(irq_w[1]));
    gpio_mmio_port #(.PIN_COUNT(N), .TRIGGER(TRIG_FALL)) uut_fall (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_w[2]), .rd_valid(rv_w[2]), .pin_in(pin_in),
        .pin_out(po_w[2]), .pin_oe(oe_w[2]), .irq(irq_w[2]));
    gpio_mmio_port #(.PIN_COUNT(N), .TRIGGER(TRIG_LEVEL)) uut_lvl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_w[3]), .rd_valid(rv_w[3]), .pin_in(pin_in),
        .pin_out(po_w[3]), .pin_oe(oe_w[3]), .irq(irq_w[3]));

    // Behavioural reference: pin history, registers, pending read.
    logic [N-1:0] hist [$];
    logic [N-1:0] m_out = '0, m_dir = '0, m_msk = '0;
    logic [N-1:0] m_cap [4];
    logic         m_rv = 1'b0;
    logic [31:0]  m_rd [4];

    function automatic logic [N-1:0] seen(input int age);
        return (hist.size() > age) ? hist[age] : '0;
    endfunction

    always @(posedge clk) begin : model
        logic [N-1:0] now_s, old_s, ev, clr;
        now_s = seen(1);
        old_s = seen(2);
        if (!rst_n) begin
            hist.delete();
            m_out = '0; m_dir = '0; m_msk = '0; m_rv = 1'b0;
            for (int k = 0; k < 4; k++) begin m_cap[k] = '0; m_rd[k] = '0; end
        end else begin
            m_rv = rd_en;
            for (int k = 0; k < 4; k++) begin
                if (rd_en) begin
                    case (addr[3:2])
                        2'd0: m_rd[k] = 32'((m_dir & m_out) | (~m_dir & now_s));
                        2'd1: m_rd[k] = 32'(m_dir);
                        2'd2: m_rd[k] = 32'(m_msk);
                        default: m_rd[k] = 32'(m_cap[k]);
                    endcase
                end
            end
            clr = (wr_en && addr[3:2] == 2'd3) ? wr_data[N-1:0] : '0;
            for (int k = 0; k < 4; k++) begin
                case (k)
                    0: ev = now_s ^ old_s;
                    1: ev = now_s & ~old_s;
                    2: ev = ~now_s & old_s;
                    default: ev = '0;
                endcase
                m_cap[k] = (m_cap[k] & ~clr) | ev;
            end
            if (wr_en) begin
                case (addr[3:2])
                    2'd0: m_out = wr_data[N-1:0];
                    2'd1: m_dir = wr_data[N-1:0];
                    2'd2: m_msk = wr_data[N-1:0];
                    default: ;
                endcase
            end
            hist.push_front(pin_in);
            if (hist.size() > 3) void'(hist.pop_back());
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison with the reference, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 4; k++) begin
                logic ie;
                ie = (k == 3) ? |(seen(1) & m_msk) : |(m_cap[k] & m_msk);
                check({phase, " irq"}, 32'(irq_w[k]), 32'(ie));
                check({phase, " rd_valid"}, 32'(rv_w[k]), 32'(m_rv));
                if (m_rv) check({phase, " rd_data"}, rd_w[k], m_rd[k]);
                check({phase, " pin_out"}, 32'(po_w[k]), 32'(m_out));
                check({phase, " pin_oe"}, 32'(oe_w[k]), 32'(m_dir));
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    logic [31:0] r [4];
    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        for (int k = 0; k < 4; k++) r[k] = rd_w[k];
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check("R1 pin_oe", 32'(oe_w[0]), 0);
        check("R1 irq", 32'(irq_w[0]), 0);
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a));
            check("R1 reg", r[0], 0);
        end

        phase = "R3";
        wr(4'h4, 32'h0F0);
        wr(4'h0, 32'h0A5);
        idle(1);
        check("R3 pin_oe", 32'(oe_w[0]), 32'h0F0);
        check("R3 pin_out", 32'(po_w[0]), 32'h0A5);
        phase = "R2";
        wr(4'h8, 32'h123);
        rd(4'h8); check("R2 mask offset", r[0], 32'h123);
        rd(4'h4); check("R2 dir offset", r[0], 32'h0F0);

        phase = "R4";
        pin_in = 12'h30F;
        idle(4);
        rd(4'h0); check("R4 pin view", r[0], (32'h0F0 & 32'h0A5) | (~32'h0F0 & 32'h30F & 32'hFFF));

        phase = "R5";
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4); check("R5 dir upper", r[0], 32'hFFF);
        wr(4'h0, 32'hFFFF_F000);
        rd(4'h0); check("R5 data upper", r[0], 32'h000);
        wr(4'h4, 32'h0);

        phase = "R7";
        wr(4'hC, 32'hFFF);
        rd(4'hC);
        for (int k = 0; k < 4; k++) check("R7 cleared", r[k], 0);

        phase = "R6";
        pin_in = 12'h001;
        idle(4);
        rd(4'hC);
        check("R6 both", r[0], 32'h30E);
        check("R6 rise", r[1], 32'h000);
        check("R6 fall", r[2], 32'h30E);
        check("R10 level cap", r[3], 32'h000);

        phase = "R7";
        wr(4'hC, 32'h000);
        rd(4'hC); check("R7 zero write", r[0], 32'h30E);
        wr(4'hC, 32'h00E);
        rd(4'hC); check("R7 one write", r[0], 32'h300);

        phase = "R9";
        idle(1);
        check("R9 both irq", 32'(irq_w[0]), 1);
        check("R9 rise irq", 32'(irq_w[1]), 0);
        check("R10 level irq", 32'(irq_w[3]), 1);
        wr(4'h8, 32'h0);
        idle(1);
        check("R9 masked", 32'(irq_w[0]), 0);

        phase = "R10";
        wr(4'h8, 32'h010);
        pin_in = 12'h011;
        idle(3);
        check("R10 level high", 32'(irq_w[3]), 1);
        pin_in = 12'h001;
        idle(3);
        check("R10 level low", 32'(irq_w[3]), 0);
        check("R10 edge still", 32'(irq_w[0]), 1);

        phase = "R8";
        wr(4'hC, 32'hFFF);
        idle(2);
        pin_in = 12'h021;
        @(negedge clk);
        wr(4'hC, 32'h020);
        rd(4'hC);
        check("R8 both kept", r[0], 32'h020);
        check("R8 rise kept", r[1], 32'h020);

        phase = "R6";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            pin_in  = N'($urandom);
            wr_en   = ($urandom % 4) == 0;
            rd_en   = ($urandom % 3) == 0;
            addr    = {2'($urandom), 2'b00};
            wr_data = $urandom;
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        idle(4);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule